// File: doc/BRIEF.md
# Indexed Shape Allocation Unit

This unit carries out two shape-install commands that share one datapath. The opcode bit picks between them. The indexed variant builds a shape that tells an address generator to fetch element indices from a general register. The offset variant builds a plain matrix shape with a start offset. Each command gives a first dimension. The unit searches upward for the smallest second dimension whose product with the first dimension covers the current maximum vector length. It then assembles a 32-bit shape template.

The template is written into one or more of four shape registers, steered by a 5-bit operand mask and a mode bit. In the default mode, every shape and every operand slot index is cleared first. The selected operands then receive shape numbers in round-robin order, wrapping modulo 4. In the refined mode, exactly one operand/shape pair is written and all other state is kept. A persistence bit copies the mode bit.

Commands enter on a valid/ready handshake. A requester holds `cmd_valid` and all command fields steady until it sees `cmd_ready` high at a rising edge. The unit drops `cmd_ready` from acceptance until the write completes, so one command is in flight at a time. The shapes and per-operand fields are plain level outputs, and `done_o` pulses when they carry the new values.

Top module: `shape_alloc_unit`

## Requirements
- R1: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly when no command is in flight. Commands offered while `cmd_ready` is low have no effect, and the result equals that of the accepted command.
- R2: The search value d is the smallest value, counted up from 0, with d*(`cmd_dim`+1) >= `cmd_maxvl`. It stops at 63 if no smaller value qualifies. `done_o` is high in the cycle after the (d+2)-th rising edge that follows the accepting edge.
- R3: `done_o` is a one-cycle pulse. `shapes_o`, `slot_idx_o`, `enable_o` and `persist_o` change only on the edge that raises `done_o`, and hold their values until the next command completes.
- R4: Every template has the following common fields. Bits [5:0] hold `cmd_dim` zero-extended, and bits [31:30] are 00. With `cmd_yx`=0, bits [11:6] are 0 when `cmd_skip`=0 and 63 when `cmd_skip`=1. With `cmd_yx`=1, bits [11:6] are 0 when `cmd_skip`=1 and d-1 modulo 64 when `cmd_skip`=0.
- R5: Indexed variant (`cmd_offset_mode`=0): bits [20:18] are 110 for `cmd_yx`=0 and 111 for `cmd_yx`=1. Bits [17:12] hold `cmd_gpr` zero-extended, bits [29:28] hold `cmd_ew`, bit 21 holds `cmd_skip`, and bits [27:24] are 0.
- R6: Offset variant (`cmd_offset_mode`=1): bits [20:18] are 000 for `cmd_yx`=0 and 010 for `cmd_yx`=1. Bits [27:24] hold `cmd_offs`, and bits [29:28] are 01 when `cmd_skip`=1 and 00 otherwise. Bits [17:12] and bit 21 are 0.
- R7: With `cmd_mm`=0, all four shapes and `slot_idx_o` are cleared and `enable_o` takes `cmd_mask`. Operand slots b=0..4 are then scanned in order, where slot b is selected by mask bit 4-b. Each selected slot writes the template to shape number p, which is `shapes_o[32p+31:32p]`, and records p in `slot_idx_o[2b+1:2b]`. The value of p starts at 0 and advances modulo 4.
- R8: With `cmd_mm`=1, the slot number is `cmd_mask[4:2]` and the shape number is `cmd_mask[1:0]`. Only that shape is written. For a slot number of 0..4, its `slot_idx_o` field takes the shape number and `enable_o` bit 4-slot is set. For a slot number of 5..7, only the shape is written. All other shapes, fields and enable bits keep their values.
- R9: `persist_o` takes the value of `cmd_mm` of the completed command.
- R10: After reset, all shapes, `slot_idx_o`, `enable_o` and `persist_o` are zero, `done_o` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_offset_mode | input | 1 | 0 indexed variant, 1 offset variant |
| cmd_dim | input | 5 | First dimension minus one |
| cmd_yx | input | 1 | 0 x/y ordering, 1 y/x ordering |
| cmd_skip | input | 1 | Skip first dimension |
| cmd_mm | input | 1 | 0 round-robin mode, 1 refined mode |
| cmd_mask | input | 5 | Operand mask, or slot/shape select in refined mode |
| cmd_gpr | input | 5 | Index register number (indexed variant) |
| cmd_ew | input | 2 | Element-width override (indexed variant) |
| cmd_offs | input | 4 | Element offset (offset variant) |
| cmd_maxvl | input | 7 | Current maximum vector length |
| done_o | output | 1 | Pulse: outputs carry the completed command |
| shapes_o | output | 128 | Four shape registers, shape p at [32p+31:32p] |
| slot_idx_o | output | 10 | Shape number per operand slot, slot b at [2b+1:2b] |
| enable_o | output | 5 | Per-operand remap enable, bit 4 is slot 0 |
| persist_o | output | 1 | Persistence bit |

## Verification
A full mask of five operands sends the fifth slot back to shape 0. A counter that does not wrap would record 4 truncated or leave shape 0 with a stale value. A search that cannot reach the target within 6 bits must stop at 63 and finish after 65 edges, where a broken counter would wrap to 0 and run forever. A zero maximum length must give d=0 and a y/x second dimension of 63. A refined command must touch one shape only, and a slot number above 4 must leave every index and enable field alone; a design that cleared state or decoded the slot number loosely would corrupt neighbours. Commands offered while busy must be ignored: the command in flight must finish unchanged and the offered command must not take effect afterwards.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int SHAPE_W    = 32;
  localparam int NUM_SHAPES = 4;
  localparam int NUM_SLOTS  = 5;
  localparam int SEL_W      = $clog2(NUM_SHAPES);
  localparam int SLOT_NUM_W = 3;
  localparam int FIELD_W    = 6;
  localparam int DIM_W      = 5;
  localparam int GPR_W      = 5;
  localparam int EW_W       = 2;
  localparam int OFFS_W     = 4;
  localparam int MVL_W      = 7;

  // template field positions (consumed by the address generators)
  localparam int XD_LSB   = 0;
  localparam int YD_LSB   = 6;
  localparam int ZD_LSB   = 12;
  localparam int PERM_LSB = 18;
  localparam int SK1_BIT  = 21;
  localparam int OFF_LSB  = 24;
  localparam int SKW_LSB  = 28;
  localparam int MODE_LSB = 30;

  typedef logic [SHAPE_W-1:0] shape_t;
  typedef logic [NUM_SHAPES-1:0][SHAPE_W-1:0] shape_bank_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_WRITE} phase_t;

  typedef struct packed {
    logic                offset_mode;
    logic [DIM_W-1:0]    dim;
    logic                yx;
    logic                skip;
    logic                mm;
    logic [NUM_SLOTS-1:0] mask;
    logic [GPR_W-1:0]    gpr;
    logic [EW_W-1:0]     ew;
    logic [OFFS_W-1:0]   offs;
    logic [MVL_W-1:0]    maxvl;
  } cmd_t;
endpackage

// File: rtl/shp_dim_search.sv
module shp_dim_search #(
  parameter int MVL_W = 7,
  parameter int DIM_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MVL_W-1:0] maxvl,
  input  logic [DIM_W-1:0] dim_m1,
  output logic             found,
  output logic [CNT_W-1:0] d
);
  localparam int PW = (CNT_W + DIM_W + 1 > MVL_W) ? CNT_W + DIM_W + 1 : MVL_W;

  logic             run_q;
  logic [CNT_W-1:0] d_q;
  logic [PW-1:0]    prod;
  logic             hit;
  logic             sat;

  assign prod  = PW'(d_q) * (PW'(dim_m1) + PW'(1));
  assign hit   = prod >= PW'(maxvl);
  assign sat   = &d_q;
  assign found = run_q && (hit || sat);
  assign d     = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      d_q   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      d_q   <= '0;
    end else if (run_q) begin
      if (found) run_q <= 1'b0;
      else       d_q   <= d_q + 1'b1;
    end
  end

  // R2: one step per clock while the target is not met
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !found && !start) |=> (d_q == $past(d_q) + 1'b1));

  // R2: the stop condition fires once per search
  assert_found_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);
endmodule

// File: rtl/shp_template.sv
module shp_template
  import shp_pkg::*;
(
  input  logic               offset_mode,
  input  logic [DIM_W-1:0]   dim,
  input  logic               yx,
  input  logic               skip,
  input  logic [GPR_W-1:0]   gpr,
  input  logic [EW_W-1:0]    ew,
  input  logic [OFFS_W-1:0]  offs,
  input  logic [FIELD_W-1:0] d,
  output shape_t             shape
);
  always_comb begin
    shape = '0;
    shape[XD_LSB +: FIELD_W] = FIELD_W'(dim);
    if (!yx) shape[YD_LSB +: FIELD_W] = skip ? '1 : '0;
    else     shape[YD_LSB +: FIELD_W] = skip ? '0 : d - 1'b1;
    if (!offset_mode) begin
      shape[PERM_LSB +: 3]       = yx ? 3'b111 : 3'b110;
      shape[ZD_LSB +: FIELD_W]   = FIELD_W'(gpr);
      shape[SKW_LSB +: EW_W]     = ew;
      shape[SK1_BIT]             = skip;
    end else begin
      shape[PERM_LSB +: 3]       = yx ? 3'b010 : 3'b000;
      shape[OFF_LSB +: OFFS_W]   = offs;
      shape[SKW_LSB +: 2]        = skip ? 2'b01 : 2'b00;
    end
    shape[MODE_LSB +: 2] = 2'b00;
  end
endmodule

// File: rtl/shp_slot_alloc.sv
module shp_slot_alloc
  import shp_pkg::*;
(
  input  logic                         mm,
  input  logic [NUM_SLOTS-1:0]         mask,
  input  shape_t                       tmpl,
  input  shape_bank_t                  cur_shapes,
  input  logic [NUM_SLOTS*SEL_W-1:0]   cur_idx,
  input  logic [NUM_SLOTS-1:0]         cur_en,
  output shape_bank_t                  nxt_shapes,
  output logic [NUM_SLOTS*SEL_W-1:0]   nxt_idx,
  output logic [NUM_SLOTS-1:0]         nxt_en
);
  logic [SEL_W-1:0]      ptr;
  logic [SLOT_NUM_W-1:0] slot;
  logic [SEL_W-1:0]      sel;

  assign slot = mask[NUM_SLOTS-1 -: SLOT_NUM_W];
  assign sel  = mask[SEL_W-1:0];

  always_comb begin
    ptr = '0;
    if (!mm) begin
      nxt_shapes = '0;
      nxt_idx    = '0;
      nxt_en     = mask;
      for (int b = 0; b < NUM_SLOTS; b++) begin
        if (mask[NUM_SLOTS-1-b]) begin
          nxt_shapes[ptr]          = tmpl;
          nxt_idx[b*SEL_W +: SEL_W] = ptr;
          ptr                      = ptr + 1'b1;
        end
      end
    end else begin
      nxt_shapes      = cur_shapes;
      nxt_idx         = cur_idx;
      nxt_en          = cur_en;
      nxt_shapes[sel] = tmpl;
      for (int b = 0; b < NUM_SLOTS; b++) begin
        if (slot == SLOT_NUM_W'(b)) begin
          nxt_idx[b*SEL_W +: SEL_W] = sel;
          nxt_en[NUM_SLOTS-1-b]     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shape_alloc_unit.sv
module shape_alloc_unit
  import shp_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic                            cmd_offset_mode,
  input  logic [DIM_W-1:0]                cmd_dim,
  input  logic                            cmd_yx,
  input  logic                            cmd_skip,
  input  logic                            cmd_mm,
  input  logic [NUM_SLOTS-1:0]            cmd_mask,
  input  logic [GPR_W-1:0]                cmd_gpr,
  input  logic [EW_W-1:0]                 cmd_ew,
  input  logic [OFFS_W-1:0]               cmd_offs,
  input  logic [MVL_W-1:0]                cmd_maxvl,
  output logic                            done_o,
  output logic [NUM_SHAPES*SHAPE_W-1:0]   shapes_o,
  output logic [NUM_SLOTS*SEL_W-1:0]      slot_idx_o,
  output logic [NUM_SLOTS-1:0]            enable_o,
  output logic                            persist_o
);
  phase_t                     phase_q;
  cmd_t                       cmd_q;
  cmd_t                       cmd_in;
  shape_bank_t                shapes_q;
  shape_bank_t                shapes_nx;
  logic [NUM_SLOTS*SEL_W-1:0] idx_q;
  logic [NUM_SLOTS*SEL_W-1:0] idx_nx;
  logic [NUM_SLOTS-1:0]       en_q;
  logic [NUM_SLOTS-1:0]       en_nx;
  logic                       persist_q;
  logic                       done_q;
  logic                       start;
  logic                       found;
  logic [FIELD_W-1:0]         d_val;
  shape_t                     tmpl;

  assign cmd_in = '{offset_mode: cmd_offset_mode, dim: cmd_dim, yx: cmd_yx,
                    skip: cmd_skip, mm: cmd_mm, mask: cmd_mask, gpr: cmd_gpr,
                    ew: cmd_ew, offs: cmd_offs, maxvl: cmd_maxvl};

  assign cmd_ready = (phase_q == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;

  shp_dim_search #(.MVL_W(MVL_W), .DIM_W(DIM_W), .CNT_W(FIELD_W)) u_search (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .maxvl  (cmd_q.maxvl),
    .dim_m1 (cmd_q.dim),
    .found  (found),
    .d      (d_val)
  );

  shp_template u_tmpl (
    .offset_mode (cmd_q.offset_mode),
    .dim         (cmd_q.dim),
    .yx          (cmd_q.yx),
    .skip        (cmd_q.skip),
    .gpr         (cmd_q.gpr),
    .ew          (cmd_q.ew),
    .offs        (cmd_q.offs),
    .d           (d_val),
    .shape       (tmpl)
  );

  shp_slot_alloc u_alloc (
    .mm         (cmd_q.mm),
    .mask       (cmd_q.mask),
    .tmpl       (tmpl),
    .cur_shapes (shapes_q),
    .cur_idx    (idx_q),
    .cur_en     (en_q),
    .nxt_shapes (shapes_nx),
    .nxt_idx    (idx_nx),
    .nxt_en     (en_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= ST_IDLE;
      cmd_q     <= '0;
      shapes_q  <= '0;
      idx_q     <= '0;
      en_q      <= '0;
      persist_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        ST_IDLE: if (cmd_valid) begin
          cmd_q   <= cmd_in;
          phase_q <= ST_SEARCH;
        end
        ST_SEARCH: if (found) phase_q <= ST_WRITE;
        ST_WRITE: begin
          shapes_q  <= shapes_nx;
          idx_q     <= idx_nx;
          en_q      <= en_nx;
          persist_q <= cmd_q.mm;
          done_q    <= 1'b1;
          phase_q   <= ST_IDLE;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign shapes_o   = shapes_q;
  assign slot_idx_o = idx_q;
  assign enable_o   = en_q;
  assign persist_o  = persist_q;

  // R1: acceptance closes the door until the write completes
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !cmd_ready);

  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: visible state moves only with the completion pulse
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(shapes_o) && $stable(slot_idx_o) && $stable(enable_o) && $stable(persist_o)));

  // R9: persistence follows the command that just completed
  assert_persist_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (persist_o == cmd_q.mm));

  // R7: round-robin mode copies the whole mask into the enables
  assert_mask_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cmd_q.mm) |-> (enable_o == cmd_q.mask));

  // R4: no shape ever leaves the matrix/indexed mode
  generate
    for (genvar p = 0; p < NUM_SHAPES; p++) begin : g_mode_chk
      assert_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shapes_q[p][MODE_LSB +: 2] == 2'b00);
    end
  endgenerate
endmodule

// File: tb/shape_alloc_unit_test.sv
`timescale 1ns/1ps
module shape_alloc_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_offset_mode = 1'b0;
  logic [4:0] cmd_dim = '0;
  logic cmd_yx = 1'b0;
  logic cmd_skip = 1'b0;
  logic cmd_mm = 1'b0;
  logic [4:0] cmd_mask = '0;
  logic [4:0] cmd_gpr = '0;
  logic [1:0] cmd_ew = '0;
  logic [3:0] cmd_offs = '0;
  logic [6:0] cmd_maxvl = '0;
  logic done_o;
  logic [127:0] shapes_o;
  logic [9:0] slot_idx_o;
  logic [4:0] enable_o;
  logic persist_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [3:0][31:0] m_shape = '0;
  logic [9:0] m_idx = '0;
  logic [4:0] m_en = '0;
  logic m_per = 1'b0;

  always #5 clk = ~clk;

  shape_alloc_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_offset_mode(cmd_offset_mode), .cmd_dim(cmd_dim), .cmd_yx(cmd_yx),
    .cmd_skip(cmd_skip), .cmd_mm(cmd_mm), .cmd_mask(cmd_mask), .cmd_gpr(cmd_gpr),
    .cmd_ew(cmd_ew), .cmd_offs(cmd_offs), .cmd_maxvl(cmd_maxvl), .done_o(done_o),
    .shapes_o(shapes_o), .slot_idx_o(slot_idx_o), .enable_o(enable_o), .persist_o(persist_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] f_d(input logic [6:0] mvl, input logic [4:0] dm);
    int d = 0;
    while (d < 63 && d * (int'(dm) + 1) < int'(mvl)) d++;
    return 6'(d);
  endfunction

  function automatic logic [31:0] f_tmpl(input logic ofs, input logic [4:0] dm, input logic yx,
      input logic sk, input logic [4:0] g, input logic [1:0] ew, input logic [3:0] of, input logic [5:0] d);
    logic [31:0] s = '0;
    s[5:0] = {1'b0, dm};
    if (!yx) s[11:6] = sk ? 6'd63 : 6'd0;
    else     s[11:6] = sk ? 6'd0 : d - 6'd1;
    if (!ofs) begin
      s[20:18] = yx ? 3'b111 : 3'b110;
      s[17:12] = {1'b0, g};
      s[29:28] = ew;
      s[21]    = sk;
    end else begin
      s[20:18] = yx ? 3'b010 : 3'b000;
      s[27:24] = of;
      s[29:28] = sk ? 2'b01 : 2'b00;
    end
    return s;
  endfunction

  task automatic model(input logic [31:0] t, input logic mm, input logic [4:0] mask);
    int p = 0;
    int slot;
    if (!mm) begin
      m_shape = '0; m_idx = '0; m_en = mask;
      for (int b = 0; b < 5; b++) begin
        if (mask[4-b]) begin
          m_shape[p] = t;
          m_idx[2*b +: 2] = 2'(p);
          p = (p + 1) % 4;
        end
      end
    end else begin
      slot = int'(mask[4:2]);
      m_shape[mask[1:0]] = t;
      if (slot < 5) begin
        m_idx[2*slot +: 2] = mask[1:0];
        m_en[4-slot] = 1'b1;
      end
    end
    m_per = mm;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " shapes R7/R8"}, shapes_o, m_shape);
    chk({tag, " slot index R7/R8"}, 128'(slot_idx_o), 128'(m_idx));
    chk({tag, " enables R7/R8"}, 128'(enable_o), 128'(m_en));
    chk({tag, " persist R9"}, 128'(persist_o), 128'(m_per));
  endtask

  // drive one command, measure latency (R2), update the model, compare
  task automatic run_cmd(input string tag, input logic ofs, input logic [4:0] dm, input logic yx,
      input logic sk, input logic mm, input logic [4:0] mask, input logic [4:0] g,
      input logic [1:0] ew, input logic [3:0] of, input logic [6:0] mvl);
    logic [5:0] d;
    int lat = -1;
    d = f_d(mvl, dm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_offset_mode = ofs; cmd_dim = dm; cmd_yx = yx; cmd_skip = sk;
    cmd_mm = mm; cmd_mask = mask; cmd_gpr = g; cmd_ew = ew; cmd_offs = of; cmd_maxvl = mvl;
    chk({tag, " ready when idle R1"}, 128'(cmd_ready), 128'(1));
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) begin lat = k; break; end
    end
    chk({tag, " latency R2"}, 128'(lat), 128'(int'(d) + 2));
    model(f_tmpl(ofs, dm, yx, sk, g, ew, of, d), mm, mask);
    check_outputs(tag);
    @(negedge clk);
    chk({tag, " done pulse R3"}, 128'(done_o), 128'(0));
    check_outputs({tag, " hold R3"});
  endtask

  task automatic t_reset;
    chk("reset shapes R10", shapes_o, '0);
    chk("reset index R10", 128'(slot_idx_o), '0);
    chk("reset enables R10", 128'(enable_o), '0);
    chk("reset persist R10", 128'(persist_o), '0);
    chk("reset done R10", 128'(done_o), '0);
    chk("reset ready R10", 128'(cmd_ready), 128'(1));
  endtask

  task automatic t_indexed_xy;
    // slots 0,2,3 selected -> shapes 0,1,2
    run_cmd("R5 indexed x/y", 1'b0, 5'd3, 1'b0, 1'b1, 1'b0, 5'b10110, 5'd9, 2'b10, 4'd0, 7'd10);
    chk("R5 literal template", 128'(shapes_o[31:0]), 128'(32'h20389FC3));
    chk("R7 slot3 index", 128'(slot_idx_o[7:6]), 128'(2));
  endtask

  task automatic t_indexed_yx_wrap;
    // five operands: fifth wraps back to shape 0
    run_cmd("R7 wrap R4", 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'b11111, 5'd17, 2'b01, 4'd0, 7'd10);
    chk("R7 slot4 wraps to 0", 128'(slot_idx_o[9:8]), 128'(0));
    chk("R4 ydim d-1", 128'(shapes_o[11:6]), 128'(2));
  endtask

  task automatic t_offset;
    run_cmd("R6 offset y/x skip", 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, 5'b01001, 5'd31, 2'b11, 4'd11, 7'd64);
    chk("R6 skip field 01", 128'(shapes_o[29:28]), 128'(1));
    run_cmd("R6 offset x/y", 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 5'b00010, 5'd5, 2'b10, 4'd6, 7'd9);
  endtask

  task automatic t_refined;
    run_cmd("R8 refined slot3 shape2", 1'b1, 5'd4, 1'b1, 1'b0, 1'b1, {3'd3, 2'd2}, 5'd0, 2'b00, 4'd3, 7'd23);
    run_cmd("R8 refined slot0 shape3", 1'b0, 5'd2, 1'b0, 1'b0, 1'b1, {3'd0, 2'd3}, 5'd12, 2'b01, 4'd0, 7'd5);
    run_cmd("R8 refined slot6 only shape", 1'b0, 5'd6, 1'b1, 1'b1, 1'b1, {3'd6, 2'd1}, 5'd2, 2'b11, 4'd0, 7'd30);
  endtask

  task automatic t_clear;
    run_cmd("R7 clear after refined", 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00001, 5'd0, 2'b00, 4'd1, 7'd3);
  endtask

  task automatic t_corners;
    run_cmd("R2 saturate 63", 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 5'b10000, 5'd1, 2'b00, 4'd0, 7'd127);
    chk("R2 saturated ydim", 128'(shapes_o[11:6]), 128'(62));
    run_cmd("R2 maxvl zero R4", 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 5'b01000, 5'd1, 2'b00, 4'd0, 7'd0);
    chk("R4 ydim wraps to 63", 128'(shapes_o[11:6]), 128'(63));
  endtask

  task automatic t_busy_ignore;
    logic [5:0] d;
    int lat = -1;
    int ready_seen = 0;
    d = f_d(7'd40, 5'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_offset_mode = 1'b1; cmd_dim = 5'd0; cmd_yx = 1'b1; cmd_skip = 1'b0;
    cmd_mm = 1'b0; cmd_mask = 5'b00100; cmd_gpr = '0; cmd_ew = '0; cmd_offs = 4'd9; cmd_maxvl = 7'd40;
    @(posedge clk);
    @(negedge clk);
    // offer a conflicting command while busy
    cmd_offset_mode = 1'b0; cmd_mm = 1'b1; cmd_mask = 5'b11111; cmd_maxvl = 7'd1; cmd_dim = 5'd9;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (cmd_ready && !done_o) ready_seen++;
      if (k == 10) cmd_valid = 1'b0;
      if (done_o) begin lat = k; break; end
    end
    chk("R1 ready low while busy", 128'(ready_seen), 128'(0));
    chk("R1 latency of first command R2", 128'(lat), 128'(int'(d) + 2));
    model(f_tmpl(1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 2'b00, 4'd9, d), 1'b0, 5'b00100);
    check_outputs("R1 busy command ignored");
    repeat (3) @(negedge clk);
    check_outputs("R1 no late acceptance");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indexed_xy();
    t_indexed_yx_wrap();
    t_offset();
    t_refined();
    t_clear();
    t_corners();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule